// File: doc/BRIEF.md
# Two-Stage Correction Sequencer

This block paces the error-correction path of a cache memory controller with two cascaded table-driven sequencers. A handoff from the memory stage starts the first sequencer. It picks a function code from the kind of reference, captures the request serial number, the trouble tag and the write-protect tag, and then walks through up to eight steps. At a step chosen by its table it launches the second sequencer, which inherits its function code, serial number and trouble tag and runs its own step sequence.

Each sequencer state is five bits wide: a two-bit function in the upper bits and a three-bit step counter in the lower bits. A 32-word lookup table per stage, indexed by the current state, supplies per-step flags (free, wants-address, wants-pipe, map-wait, launch) and three strobes shared by both stages. A stage's shared-strobe contribution is reloaded only on cycles where that stage steps, and the shared strobes are the OR of both contributions. Both tables are parameters.

Top module: `ecc_seq_top`

## Requirements
- R1: While reset is high and on the first cycle after it, both stages are free and idle, both states are 0, the shared strobes are 0, the stage-2 launch flag is 0 and both serial numbers are 0.
- R2: A start loads stage 1 on the next clock with function 3 for a dirty I/O fetch, else 2 for an I/O fetch, else 1 if the reference uses the D bus, else 0, with step 0, clears its free flag, clears wants-address and captures serial, trouble and write-protect. A start also overrides a stage that is still busy.
- R3: Stage 1 is idle exactly when its free flag is set and start is low; while idle its state and outputs hold.
- R4: When stage 1 is neither idle nor starting, it steps: the step field (bits 2:0) increments modulo 8 and the function field (bits 4:3) is unchanged.
- R5: On a stage-1 step, the flags load from its table word at the current state: free becomes the inverse of bit 1 and wants-address becomes bit 2.
- R6: A stage-1 step whose table word has bit 0 low is a launch: on the next clock stage 2 has state {stage-1 function, step 0}, stage-1's serial number and trouble tag, free low, wants-pipe low and map-wait low, and the launch flag is high for exactly that one cycle.
- R7: Stage 2 is idle exactly when its free flag is set and the launch flag is low; while idle its state holds.
- R8: When stage 2 is not idle and no launch is occurring, it steps like stage 1 and loads from its table word at the current state: free is bit 3, wants-pipe is the inverse of bit 2 and map-wait is bit 1.
- R9: The shared strobes (index 0 make-D-from-correction, 1 output-next, 2 make-output-from-D) come from stage-1 table bits 5:3 and stage-2 table bits 6:4. When both stages step, they become the OR of both words; when only one steps, they become its word ORed with the other stage's last contribution; when neither steps, they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Handoff from the memory stage, starts stage 1 |
| dirty_io_i | input | 1 | Reference is a dirty I/O fetch |
| io_fetch_i | input | 1 | Reference is an I/O fetch |
| uses_d_i | input | 1 | Reference uses the D bus |
| serial_i | input | SRN_W | Request serial number |
| trouble_i | input | 1 | Map trouble tag |
| wprot_i | input | 1 | Write-protect tag |
| s1_state_o | output | 5 | Stage-1 state {function, step} |
| s1_free_o | output | 1 | Stage-1 free flag |
| s1_idle_o | output | 1 | Stage-1 idle |
| s1_wants_addr_o | output | 1 | Stage-1 wants the address |
| s1_serial_o | output | SRN_W | Stage-1 serial number |
| s1_trouble_o | output | 1 | Stage-1 trouble tag |
| s1_wprot_o | output | 1 | Stage-1 write-protect tag |
| s2_state_o | output | 5 | Stage-2 state {function, step} |
| s2_start_o | output | 1 | Stage-2 launch flag |
| s2_free_o | output | 1 | Stage-2 free flag |
| s2_idle_o | output | 1 | Stage-2 idle |
| s2_wants_pipe_o | output | 1 | Stage-2 wants the pipe |
| s2_map_wait_o | output | 1 | Stage-2 map-wait request |
| s2_serial_o | output | SRN_W | Stage-2 serial number |
| s2_trouble_o | output | 1 | Stage-2 trouble tag |
| strobe_o | output | 3 | Shared strobes |

## Verification
A wrong stage-1 state appears on the state port the next cycle and, through the table, as wrong free, wants-address or strobe values one step later, or as a launch on the wrong step. A broken handoff shows at the stage-2 state, serial and trouble ports on the cycle after the launch. A bad strobe merge is only visible when the stages step at different times, so the stimulus mixes restarts, overlapping runs and long idle gaps, and the model is compared on every cycle so that each fault surfaces within a cycle or two of its cause. A second instance with a table that never frees runs the step counter through its wrap.

// File: rtl/ecc_seq_pkg.sv
package ecc_seq_pkg;

    localparam int FUNC_W    = 2;
    localparam int STEP_W    = 3;
    localparam int STATE_W   = FUNC_W + STEP_W;
    localparam int ROM_DEPTH = 1 << STATE_W;
    localparam int ROM_W     = 8;
    localparam int NSTB      = 3;

    // stage-1 table word fields
    localparam int S1B_LAUNCH_N = 0;
    localparam int S1B_BUSY     = 1;
    localparam int S1B_WANT_A   = 2;
    localparam int S1B_STB_LO   = 3;

    // stage-2 table word fields
    localparam int S2B_MAP_WAIT = 1;
    localparam int S2B_PIPE_N   = 2;
    localparam int S2B_FREE     = 3;
    localparam int S2B_STB_LO   = 4;

    typedef logic [ROM_W-1:0] rom_word_t;
    typedef rom_word_t [ROM_DEPTH-1:0] rom_t;

    typedef enum logic [FUNC_W-1:0] {
        FN_PLAIN    = 2'd0,
        FN_USES_D   = 2'd1,
        FN_IO_FETCH = 2'd2,
        FN_DIRTY_IO = 2'd3
    } fn_e;

    function automatic fn_e pick_fn(input logic dirty, input logic io, input logic uses_d);
        if (dirty)       return FN_DIRTY_IO;
        else if (io)     return FN_IO_FETCH;
        else if (uses_d) return FN_USES_D;
        else             return FN_PLAIN;
    endfunction

    // Default stage-1 program: plain refs finish at step 3, others at step 4.
    function automatic rom_t s1_rom_default();
        rom_t r;
        for (int i = 0; i < ROM_DEPTH; i++) begin
            logic [STEP_W-1:0] stp;
            logic [FUNC_W-1:0] fn;
            stp = STEP_W'(i);
            fn  = FUNC_W'(i >> STEP_W);
            case (stp)
                3'd0:    r[i] = 8'h07;
                3'd1:    r[i] = 8'h0B;
                3'd2:    r[i] = 8'h13;
                3'd3:    r[i] = (fn == FN_PLAIN) ? 8'h00 : 8'h23;
                3'd4:    r[i] = 8'h00;
                default: r[i] = 8'h01;
            endcase
        end
        return r;
    endfunction

    // Default stage-2 program: four active steps, then free.
    function automatic rom_t s2_rom_default();
        rom_t r;
        for (int i = 0; i < ROM_DEPTH; i++) begin
            logic [STEP_W-1:0] stp;
            logic [FUNC_W-1:0] fn;
            stp = STEP_W'(i);
            fn  = FUNC_W'(i >> STEP_W);
            case (stp)
                3'd0:    r[i] = 8'h00;
                3'd1:    r[i] = 8'h10;
                3'd2:    r[i] = (fn == FN_DIRTY_IO) ? 8'h32 : 8'h22;
                3'd3:    r[i] = 8'h4C;
                default: r[i] = 8'h0C;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/ecc_s1_ctl.sv
module ecc_s1_ctl
    import ecc_seq_pkg::*;
#(
    parameter int   SRN_W = 4,
    parameter rom_t ROM   = s1_rom_default()
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               dirty_io_i,
    input  logic               io_fetch_i,
    input  logic               uses_d_i,
    input  logic [SRN_W-1:0]   serial_i,
    input  logic               trouble_i,
    input  logic               wprot_i,
    output logic [STATE_W-1:0] state_o,
    output logic               free_o,
    output logic               idle_o,
    output logic               wants_addr_o,
    output logic [SRN_W-1:0]   serial_o,
    output logic               trouble_o,
    output logic               wprot_o,
    output logic               step_o,
    output logic               handoff_o,
    output logic [NSTB-1:0]    strobe_o
);

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic               free;
        logic               wants_a;
        logic [SRN_W-1:0]   srn;
        logic               trouble;
        logic               wprot;
    } s1_reg_t;

    localparam s1_reg_t S1_RST = '{state: '0, free: 1'b1, wants_a: 1'b0,
                                   srn: '0, trouble: 1'b0, wprot: 1'b0};

    s1_reg_t q, d;
    logic    idle_c, step_c;
    logic    rom_launch_n, rom_busy, rom_want_a;

    always_comb begin
        idle_c       = q.free & ~start_i;
        step_c       = ~q.free & ~start_i;
        rom_launch_n = ROM[q.state][S1B_LAUNCH_N];
        rom_busy     = ROM[q.state][S1B_BUSY];
        rom_want_a   = ROM[q.state][S1B_WANT_A];
        d = q;
        if (start_i) begin
            d.state   = {pick_fn(dirty_io_i, io_fetch_i, uses_d_i), {STEP_W{1'b0}}};
            d.free    = 1'b0;
            d.wants_a = 1'b0;
            d.srn     = serial_i;
            d.trouble = trouble_i;
            d.wprot   = wprot_i;
        end else if (step_c) begin
            d.state   = {q.state[STATE_W-1:STEP_W], q.state[STEP_W-1:0] + STEP_W'(1)};
            d.free    = ~rom_busy;
            d.wants_a = rom_want_a;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= S1_RST;
        else     q <= d;
    end

    assign state_o      = q.state;
    assign free_o       = q.free;
    assign idle_o       = idle_c;
    assign wants_addr_o = q.wants_a;
    assign serial_o     = q.srn;
    assign trouble_o    = q.trouble;
    assign wprot_o      = q.wprot;
    assign step_o       = step_c;
    assign handoff_o    = step_c & ~rom_launch_n;
    assign strobe_o     = ROM[q.state][S1B_STB_LO +: NSTB];

    AST_S1_START_LOAD: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (state_o[STEP_W-1:0] == '0) && !free_o && (serial_o == $past(serial_i))); // R2

    AST_S1_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        idle_o |=> $stable(state_o) && free_o); // R3

    AST_S1_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        step_o |=> (state_o[STATE_W-1:STEP_W] == $past(state_o[STATE_W-1:STEP_W]))
                && (state_o[STEP_W-1:0] == STEP_W'($past(state_o[STEP_W-1:0]) + STEP_W'(1)))); // R4

endmodule

// File: rtl/ecc_s2_ctl.sv
module ecc_s2_ctl
    import ecc_seq_pkg::*;
#(
    parameter int   SRN_W = 4,
    parameter rom_t ROM   = s2_rom_default()
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               handoff_i,
    input  logic [FUNC_W-1:0]  func_i,
    input  logic [SRN_W-1:0]   serial_i,
    input  logic               trouble_i,
    output logic [STATE_W-1:0] state_o,
    output logic               start_o,
    output logic               free_o,
    output logic               idle_o,
    output logic               wants_pipe_o,
    output logic               map_wait_o,
    output logic [SRN_W-1:0]   serial_o,
    output logic               trouble_o,
    output logic               step_o,
    output logic [NSTB-1:0]    strobe_o
);

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic               free;
        logic               start;
        logic               pipe_n;
        logic               map_wait;
        logic [SRN_W-1:0]   srn;
        logic               trouble;
    } s2_reg_t;

    localparam s2_reg_t S2_RST = '{state: '0, free: 1'b1, start: 1'b0, pipe_n: 1'b1,
                                   map_wait: 1'b0, srn: '0, trouble: 1'b0};

    s2_reg_t q, d;
    logic    idle_c, step_c;

    always_comb begin
        idle_c  = q.free & ~q.start;
        step_c  = ~idle_c & ~handoff_i;
        d       = q;
        d.start = handoff_i;
        if (handoff_i) begin
            d.state    = {func_i, {STEP_W{1'b0}}};
            d.free     = 1'b0;
            d.pipe_n   = 1'b1;
            d.map_wait = 1'b0;
            d.srn      = serial_i;
            d.trouble  = trouble_i;
        end else if (step_c) begin
            d.state    = {q.state[STATE_W-1:STEP_W], q.state[STEP_W-1:0] + STEP_W'(1)};
            d.free     = ROM[q.state][S2B_FREE];
            d.pipe_n   = ROM[q.state][S2B_PIPE_N];
            d.map_wait = ROM[q.state][S2B_MAP_WAIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= S2_RST;
        else     q <= d;
    end

    assign state_o      = q.state;
    assign start_o      = q.start;
    assign free_o       = q.free;
    assign idle_o       = idle_c;
    assign wants_pipe_o = ~q.pipe_n;
    assign map_wait_o   = q.map_wait;
    assign serial_o     = q.srn;
    assign trouble_o    = q.trouble;
    assign step_o       = step_c;
    assign strobe_o     = ROM[q.state][S2B_STB_LO +: NSTB];

    AST_S2_HANDOFF_LOAD: assert property (@(posedge clk) disable iff (rst)
        handoff_i |=> start_o && !free_o && (state_o == {$past(func_i), {STEP_W{1'b0}}})
                   && (serial_o == $past(serial_i)) && (trouble_o == $past(trouble_i))); // R6

    AST_S2_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        (start_o && !handoff_i) |=> !start_o); // R6

    AST_S2_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (idle_o && !handoff_i) |=> $stable(state_o) && free_o); // R7

endmodule

// File: rtl/ecc_strobe_or.sv
module ecc_strobe_or #(
    parameter int NSRC = 2,
    parameter int NSTB = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NSRC-1:0]           en_i,
    input  logic [NSRC-1:0][NSTB-1:0] bits_i,
    output logic [NSTB-1:0]           shared_o
);

    logic [NSRC-1:0][NSTB-1:0] contrib_q, contrib_d;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_comb contrib_d[g] = en_i[g] ? bits_i[g] : contrib_q[g];
        always_ff @(posedge clk) begin
            if (rst) contrib_q[g] <= '0;
            else     contrib_q[g] <= contrib_d[g];
        end
    end

    always_comb begin
        shared_o = '0;
        for (int i = 0; i < NSRC; i++) shared_o = shared_o | contrib_q[i];
    end

    function automatic logic [NSTB-1:0] or_all(input logic [NSRC-1:0][NSTB-1:0] b);
        logic [NSTB-1:0] acc;
        acc = '0;
        for (int i = 0; i < NSRC; i++) acc = acc | b[i];
        return acc;
    endfunction

    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en_i == '0) |=> $stable(shared_o)); // R9

    AST_STROBE_ALL: assert property (@(posedge clk) disable iff (rst)
        (&en_i) |=> (shared_o == or_all($past(bits_i)))); // R9

endmodule

// File: rtl/ecc_seq_top.sv
module ecc_seq_top
    import ecc_seq_pkg::*;
#(
    parameter int   SRN_W  = 4,
    parameter rom_t S1_ROM = s1_rom_default(),
    parameter rom_t S2_ROM = s2_rom_default()
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               dirty_io_i,
    input  logic               io_fetch_i,
    input  logic               uses_d_i,
    input  logic [SRN_W-1:0]   serial_i,
    input  logic               trouble_i,
    input  logic               wprot_i,
    output logic [STATE_W-1:0] s1_state_o,
    output logic               s1_free_o,
    output logic               s1_idle_o,
    output logic               s1_wants_addr_o,
    output logic [SRN_W-1:0]   s1_serial_o,
    output logic               s1_trouble_o,
    output logic               s1_wprot_o,
    output logic [STATE_W-1:0] s2_state_o,
    output logic               s2_start_o,
    output logic               s2_free_o,
    output logic               s2_idle_o,
    output logic               s2_wants_pipe_o,
    output logic               s2_map_wait_o,
    output logic [SRN_W-1:0]   s2_serial_o,
    output logic               s2_trouble_o,
    output logic [NSTB-1:0]    strobe_o
);

    logic            s1_step, s1_handoff, s2_step;
    logic [NSTB-1:0] s1_stb, s2_stb;

    ecc_s1_ctl #(.SRN_W(SRN_W), .ROM(S1_ROM)) u_s1 (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .dirty_io_i   (dirty_io_i),
        .io_fetch_i   (io_fetch_i),
        .uses_d_i     (uses_d_i),
        .serial_i     (serial_i),
        .trouble_i    (trouble_i),
        .wprot_i      (wprot_i),
        .state_o      (s1_state_o),
        .free_o       (s1_free_o),
        .idle_o       (s1_idle_o),
        .wants_addr_o (s1_wants_addr_o),
        .serial_o     (s1_serial_o),
        .trouble_o    (s1_trouble_o),
        .wprot_o      (s1_wprot_o),
        .step_o       (s1_step),
        .handoff_o    (s1_handoff),
        .strobe_o     (s1_stb)
    );

    ecc_s2_ctl #(.SRN_W(SRN_W), .ROM(S2_ROM)) u_s2 (
        .clk          (clk),
        .rst          (rst),
        .handoff_i    (s1_handoff),
        .func_i       (s1_state_o[STATE_W-1:STEP_W]),
        .serial_i     (s1_serial_o),
        .trouble_i    (s1_trouble_o),
        .state_o      (s2_state_o),
        .start_o      (s2_start_o),
        .free_o       (s2_free_o),
        .idle_o       (s2_idle_o),
        .wants_pipe_o (s2_wants_pipe_o),
        .map_wait_o   (s2_map_wait_o),
        .serial_o     (s2_serial_o),
        .trouble_o    (s2_trouble_o),
        .step_o       (s2_step),
        .strobe_o     (s2_stb)
    );

    ecc_strobe_or #(.NSRC(2), .NSTB(NSTB)) u_stb (
        .clk      (clk),
        .rst      (rst),
        .en_i     ({s2_step, s1_step}),
        .bits_i   ({s2_stb, s1_stb}),
        .shared_o (strobe_o)
    );

endmodule

// File: tb/ecc_seq_top_tb.sv
module ecc_seq_top_tb_top;
    import ecc_seq_pkg::*;

    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          start_i = 0, dirty_io_i = 0, io_fetch_i = 0, uses_d_i = 0, trouble_i = 0, wprot_i = 0;
    logic [SW-1:0] serial_i = '0;
    logic [4:0]    s1_state_o, s2_state_o;
    logic          s1_free_o, s1_idle_o, s1_wants_addr_o, s1_trouble_o, s1_wprot_o;
    logic          s2_start_o, s2_free_o, s2_idle_o, s2_wants_pipe_o, s2_map_wait_o, s2_trouble_o;
    logic [SW-1:0] s1_serial_o, s2_serial_o;
    logic [2:0]    strobe_o;

    ecc_seq_top #(.SRN_W(SW)) dut_i (.*);

    // second instance: stage-1 table that never frees, to reach the step wrap
    function automatic rom_t busy_rom();
        rom_t r;
        for (int i = 0; i < ROM_DEPTH; i++) r[i] = 8'h07;
        return r;
    endfunction

    logic          w_start = 0;
    logic [4:0]    w_s1_state, w_s2_state;
    logic          w_s1_free, w_s1_idle, w_s1_wa, w_s1_tr, w_s1_wp;
    logic          w_s2_st, w_s2_free, w_s2_idle, w_s2_wp, w_s2_mw, w_s2_tr;
    logic [SW-1:0] w_s1_srn, w_s2_srn;
    logic [2:0]    w_stb;

    ecc_seq_top #(.SRN_W(SW), .S1_ROM(busy_rom())) dut_wrap_i (
        .clk(clk), .rst(rst), .start_i(w_start), .dirty_io_i(1'b0), .io_fetch_i(1'b1),
        .uses_d_i(1'b0), .serial_i(4'd9), .trouble_i(1'b0), .wprot_i(1'b0),
        .s1_state_o(w_s1_state), .s1_free_o(w_s1_free), .s1_idle_o(w_s1_idle),
        .s1_wants_addr_o(w_s1_wa), .s1_serial_o(w_s1_srn), .s1_trouble_o(w_s1_tr),
        .s1_wprot_o(w_s1_wp), .s2_state_o(w_s2_state), .s2_start_o(w_s2_st),
        .s2_free_o(w_s2_free), .s2_idle_o(w_s2_idle), .s2_wants_pipe_o(w_s2_wp),
        .s2_map_wait_o(w_s2_mw), .s2_serial_o(w_s2_srn), .s2_trouble_o(w_s2_tr),
        .strobe_o(w_stb)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // behavioural reference state
    int m1_state, m1_free, m1_wa, m1_srn, m1_tr, m1_wp;
    int m2_state, m2_free, m2_start, m2_pipe, m2_mw, m2_srn, m2_tr;
    int c1, c2;
    rom_t t1, t2;

    task automatic model_reset();
        m1_state = 0; m1_free = 1; m1_wa = 0; m1_srn = 0; m1_tr = 0; m1_wp = 0;
        m2_state = 0; m2_free = 1; m2_start = 0; m2_pipe = 0; m2_mw = 0; m2_srn = 0; m2_tr = 0;
        c1 = 0; c2 = 0;
    endtask

    function automatic int next_step(int s);
        return (s / 8) * 8 + ((s % 8) + 1) % 8;
    endfunction

    // advance the reference by one clock using the inputs now being driven
    task automatic model_clock();
        int o_state, o_srn, o_tr, w, ho;
        o_state = m1_state; o_srn = m1_srn; o_tr = m1_tr; ho = 0;
        if (start_i) begin
            m1_state = 8 * (dirty_io_i ? 3 : io_fetch_i ? 2 : uses_d_i ? 1 : 0);
            m1_free = 0; m1_wa = 0; m1_srn = serial_i; m1_tr = trouble_i; m1_wp = wprot_i;
        end else if (!m1_free) begin
            w = t1[o_state];
            m1_state = next_step(o_state);
            m1_free = ((w >> 1) & 1) == 0;
            m1_wa = (w >> 2) & 1;
            ho = (w & 1) == 0;
            c1 = (w >> 3) & 7;
        end
        if (ho) begin
            m2_state = (o_state / 8) * 8; m2_free = 0; m2_pipe = 0; m2_mw = 0;
            m2_srn = o_srn; m2_tr = o_tr;
        end else if (!(m2_free && !m2_start)) begin
            w = t2[m2_state];
            m2_state = next_step(m2_state);
            m2_free = (w >> 3) & 1;
            m2_pipe = ((w >> 2) & 1) == 0;
            m2_mw = (w >> 1) & 1;
            c2 = (w >> 4) & 7;
        end
        m2_start = ho;
    endtask

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
        end
    endtask

    task automatic fld(inout bit ok, input string what, input int act, input int exp);
        if (act != exp) begin
            ok = 0;
            $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit ok = 1;
        fld(ok, "R4 s1_state",       s1_state_o,      m1_state);
        fld(ok, "R5 s1_free",        s1_free_o,       m1_free);
        fld(ok, "R3 s1_idle",        s1_idle_o,       (m1_free && !start_i) ? 1 : 0);
        fld(ok, "R5 s1_wants_addr",  s1_wants_addr_o, m1_wa);
        fld(ok, "R2 s1_serial",      s1_serial_o,     m1_srn);
        fld(ok, "R2 s1_trouble",     s1_trouble_o,    m1_tr);
        fld(ok, "R2 s1_wprot",       s1_wprot_o,      m1_wp);
        fld(ok, "R6 s2_state",       s2_state_o,      m2_state);
        fld(ok, "R6 s2_start",       s2_start_o,      m2_start);
        fld(ok, "R8 s2_free",        s2_free_o,       m2_free);
        fld(ok, "R7 s2_idle",        s2_idle_o,       (m2_free && !m2_start) ? 1 : 0);
        fld(ok, "R8 s2_wants_pipe",  s2_wants_pipe_o, m2_pipe);
        fld(ok, "R8 s2_map_wait",    s2_map_wait_o,   m2_mw);
        fld(ok, "R6 s2_serial",      s2_serial_o,     m2_srn);
        fld(ok, "R6 s2_trouble",     s2_trouble_o,    m2_tr);
        fld(ok, "R9 strobes",        strobe_o,        c1 | c2);
        n_cmp++;
        if (!ok) n_bad++;
    endtask

    task automatic cycle(input bit st, input bit dty, input bit io, input bit ud,
                         input int srn, input bit tr, input bit wp);
        start_i = st; dirty_io_i = dty; io_fetch_i = io; uses_d_i = ud;
        serial_i = SW'(srn); trouble_i = tr; wprot_i = wp;
        model_clock();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        t1 = s1_rom_default();
        t2 = s2_rom_default();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(s1_free_o && s1_idle_o && s2_free_o && s2_idle_o, "R1 both free/idle", {s1_free_o, s2_free_o}, 3);
        chk(s1_state_o == 0 && s2_state_o == 0, "R1 states zero", {s1_state_o, s2_state_o}, 0);
        chk(strobe_o == 0 && !s2_start_o, "R1 strobes/launch", {strobe_o, s2_start_o}, 0);
        rst = 0;
        @(posedge clk);
        @(negedge clk);
        compare_all();

        // R4: step wrap on the never-free instance, function 2 held
        w_start = 1;
        @(posedge clk);
        @(negedge clk);
        w_start = 0;
        chk(w_s1_state == 5'd16, "R2 wrap inst start load", w_s1_state, 16);
        for (int k = 1; k <= 11; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk(w_s1_state == 5'(16 + k % 8) && !w_s1_free, "R4 step wrap", w_s1_state, 16 + k % 8);
        end

        // R2: each function code, run to completion
        cycle(1, 1, 1, 1, 5, 1, 1);
        chk(s1_state_o == 5'd24 && s1_wprot_o, "R2 dirty I/O fetch -> func 3", s1_state_o, 24);
        repeat (14) cycle(0, 0, 0, 0, 0, 0, 0);
        cycle(1, 0, 1, 1, 6, 0, 0);
        chk(s1_state_o == 5'd16, "R2 I/O fetch -> func 2", s1_state_o, 16);
        repeat (14) cycle(0, 0, 0, 0, 0, 0, 0);
        cycle(1, 0, 0, 1, 7, 1, 0);
        chk(s1_state_o == 5'd8, "R2 uses D -> func 1", s1_state_o, 8);
        repeat (14) cycle(0, 0, 0, 0, 0, 0, 0);
        cycle(1, 0, 0, 0, 3, 0, 1);
        chk(s1_state_o == 5'd0, "R2 plain -> func 0", s1_state_o, 0);
        repeat (3) cycle(0, 0, 0, 0, 0, 0, 0);
        // R2: restart while busy, overlapping with stage 2
        cycle(1, 1, 0, 0, 12, 1, 0);
        cycle(0, 0, 0, 0, 0, 0, 0);
        cycle(1, 0, 1, 0, 13, 0, 1);
        chk(s1_state_o == 5'd16 && s1_serial_o == 4'd13, "R2 restart while busy", s1_state_o, 16);
        repeat (10) cycle(0, 0, 0, 0, 0, 0, 0);

        // mixed traffic
        for (int n = 0; n < 4000; n++) begin
            cycle(($urandom_range(0, 5) == 0), 1'($urandom), 1'($urandom), 1'($urandom),
                  int'($urandom_range(0, 15)), 1'($urandom), 1'($urandom));
        end
        repeat (12) cycle(0, 0, 0, 0, 0, 0, 0);
        chk(s1_idle_o && s2_idle_o, "R3 R7 drained to idle", {s1_idle_o, s2_idle_o}, 3);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule